// File: doc/BRIEF.md
# One-Shot Event Timer with Free-Running Timebase

This peripheral gives software two time sources behind a small word-addressed register bus. The first is an event counter. Software writes a divisor, issues a load command that copies it into the counter, then a run command. The counter then steps down toward zero, either on every clock or, when the slow-rate select is set, once every `SLOW_DIV` clocks. When it reaches zero it raises an interrupt flag and stays at zero until software reloads it. The current count can be read at any time, so the time elapsed since the load is the divisor minus the count.

The second source is a 32-bit up-counter. It advances on every clock from reset and wraps freely, and software uses it as the system time. The interrupt path has a mask register, a masked-status view that software can read, and an acknowledge register that clears the flag when bit 0 is written as one. The interrupt output is the registered OR of the masked status.

Top module: `evt_timebase`

## Requirements
- R1: After reset the operation code is hold, the slow-rate select is 0, the mask is 0, the divisor, the event count and the timebase are 0, no interrupt is pending, and `irq_o` is low.
- R2: The control register (address 0) carries the operation code in bits [1:0]: 0 = hold, 1 = load, 2 = run. Code 3 behaves as hold. Under hold the event count does not change.
- R3: While the operation is load, each clock copies the divisor (address 1) into the event count. The count reads back at address 2, so after k counting steps the value read is the divisor minus k.
- R4: While running at full rate (control bit 4 = 0), the count drops by one per clock. The raw interrupt flag is set at the edge where the count goes from 1 to 0, and `irq_o` rises one clock later.
- R5: With control bit 4 = 1, the run command first waits `SLOW_DIV` clocks and then decrements once every `SLOW_DIV` clocks. The prescaler restarts whenever the operation is not run.
- R6: Once the count is 0 it stays at 0 while running, until software loads it again.
- R7: The masked status (address 5, bit 0) equals the raw flag ANDed with mask bit 0 (address 4). `irq_o` is a register that holds the OR of the masked status from the previous clock. A raw flag that was set while masked appears as soon as the mask is set.
- R8: Writing the acknowledge register (address 6) with bit 0 = 1 clears the raw flag. If an expiry happens on the same clock, the flag stays set.
- R9: A write to the acknowledge register with bit 0 = 0 leaves the flag and `irq_o` unchanged, whatever the other bits hold.
- R10: The timebase (address 3) increments by one on every clock after reset, modulo 2^32.
- R11: A read strobe returns data one clock later, with `bus_rvalid` high for that clock. The value is the register contents before the edge that took the strobe. The control, divisor and mask registers read back what was written.
- R12: Divisors from 2 up to 0xFFFFFFFF load and count correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one full-rate count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | CNT_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| irq_o | output | 1 | Registered timer interrupt request |

## Verification
The checker assumes that a write and a read never arrive together with an unknown address. It also assumes that software does not change the control register on the cycle it expects a hold to freeze the count; the hold property looks only at the operation already in force. The stimulus issues one bus access at a time, with an idle clock after each. Every timing check counts edges from the clock that took the control write. The minimum divisor of 2 is used to make an acknowledge fall on exactly the expiry edge.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef logic [1:0] op_t;
  localparam op_t OP_HOLD = 2'd0;
  localparam op_t OP_LOAD = 2'd1;
  localparam op_t OP_RUN  = 2'd2;

  localparam int REG_CTRL   = 0;
  localparam int REG_DIV    = 1;
  localparam int REG_COUNT  = 2;
  localparam int REG_TIME   = 3;
  localparam int REG_MASK   = 4;
  localparam int REG_MSTAT  = 5;
  localparam int REG_ACK    = 6;

  localparam int CTRL_FSEL_BIT = 4;
endpackage

// File: rtl/evt_regif.sv
module evt_regif
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [CNT_W-1:0]  time_val,
  input  logic              mstat,
  output op_t               op_q,
  output logic              fsel_q,
  output logic [CNT_W-1:0]  div_q,
  output logic              mask_q,
  output logic              ack_pulse
);
  logic             sel_ctrl, sel_div, sel_mask;
  logic [CNT_W-1:0] rd_mux;

  assign sel_ctrl  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign sel_div   = bus_wr && (bus_addr == ADDR_W'(REG_DIV));
  assign sel_mask  = bus_wr && (bus_addr == ADDR_W'(REG_MASK));
  assign ack_pulse = bus_wr && (bus_addr == ADDR_W'(REG_ACK)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_HOLD;
      fsel_q <= 1'b0;
      div_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (sel_ctrl) begin
        op_q   <= bus_wdata[1:0];
        fsel_q <= bus_wdata[CTRL_FSEL_BIT];
      end
      if (sel_div)  div_q  <= bus_wdata;
      if (sel_mask) mask_q <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      REG_CTRL:  begin
        rd_mux[1:0]           = op_q;
        rd_mux[CTRL_FSEL_BIT] = fsel_q;
      end
      REG_DIV:   rd_mux = div_q;
      REG_COUNT: rd_mux = cnt_val;
      REG_TIME:  rd_mux = time_val;
      REG_MASK:  rd_mux[0] = mask_q;
      REG_MSTAT: rd_mux[0] = mstat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/evt_downcnt.sv
module evt_downcnt
  import evt_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  op_t              op,
  input  logic             fsel,
  input  logic [CNT_W-1:0] div,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam int PRESC_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(SLOW_DIV - 1);

  logic [PRESC_W-1:0] presc_q;
  logic               tick;

  assign tick   = fsel ? (presc_q == PRESC_LAST) : 1'b1;
  assign expire = (op == OP_RUN) && tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          cnt_q   <= div;
          presc_q <= '0;
        end
        OP_RUN: begin
          presc_q <= (presc_q == PRESC_LAST) ? '0 : presc_q + 1'b1;
          if (tick && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
        end
        default: presc_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_freecnt.sv
module evt_freecnt #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TIME_W-1:0] time_q
);
  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_q + 1'b1;
  end
endmodule

// File: rtl/evt_irqctl.sv
module evt_irqctl #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] mstat,
  output logic            irq_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)           raw_q[i] <= 1'b0;
      else if (set_i[i]) raw_q[i] <= 1'b1;
      else if (clr_i[i]) raw_q[i] <= 1'b0;
    end
  end

  assign mstat = raw_q & mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |mstat;
  end
endmodule

// File: rtl/evt_timebase.sv
module evt_timebase
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o
);
  op_t              op_q;
  logic             fsel_q;
  logic [CNT_W-1:0] div_q;
  logic             mask_q;
  logic             ack_pulse;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic [CNT_W-1:0] time_q;
  logic             raw_q;
  logic             mstat;

  evt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cnt_val(cnt_q), .time_val(time_q), .mstat(mstat),
    .op_q(op_q), .fsel_q(fsel_q), .div_q(div_q), .mask_q(mask_q),
    .ack_pulse(ack_pulse)
  );

  evt_downcnt #(.CNT_W(CNT_W), .SLOW_DIV(SLOW_DIV)) u_down (
    .clk(clk), .rst(rst), .op(op_q), .fsel(fsel_q), .div(div_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  evt_freecnt #(.TIME_W(CNT_W)) u_time (
    .clk(clk), .rst(rst), .time_q(time_q)
  );

  evt_irqctl #(.NSRC(1)) u_irq (
    .clk(clk), .rst(rst),
    .set_i(expire), .clr_i(ack_pulse), .mask_i(mask_q),
    .raw_q(raw_q), .mstat(mstat), .irq_q(irq_o)
  );
endmodule

// File: rtl/evt_timebase_chk.sv
module evt_timebase_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input op_t              op,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] time_q,
  input logic             raw,
  input logic             mask,
  input logic             ack,
  input logic             expire,
  input logic             irq
);
  // R2: hold (and code 3) freezes the count
  a_r2_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (op != OP_LOAD && op != OP_RUN) |=> $stable(cnt));

  // R6: zero is sticky while running
  a_r6_zero_sticks: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RUN && cnt == '0) |=> (cnt == '0));

  // R4: flag rises only on the 1 -> 0 step
  a_r4_raw_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> (cnt == '0 && $past(cnt) == CNT_W'(1)));

  // R8: acknowledge clears when no expiry competes
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !expire) |=> !raw);

  // R8: expiry wins over a same-cycle acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    expire |=> raw);

  // R7: masked off means no request next cycle
  a_r7_mask_gate: assert property (@(posedge clk) disable iff (rst)
    !mask |=> !irq);

  // R10: timebase steps by one
  a_r10_time_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (time_q == $past(time_q) + 1'b1));
endmodule

bind evt_timebase evt_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .op(op_q), .cnt(cnt_q), .time_q(time_q),
  .raw(raw_q), .mask(mask_q), .ack(ack_pulse), .expire(expire), .irq(irq_o)
);

// File: tb/tb_evt_timebase.sv
module tb_evt_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 32;
  localparam int SLOW   = 4;

  localparam int A_CTRL = 0, A_DIV = 1, A_CNT = 2, A_TIME = 3;
  localparam int A_MASK = 4, A_MST = 5, A_ACK = 6;
  localparam logic [31:0] C_HOLD = 32'h0, C_LOAD = 32'h1, C_RUN = 32'h2, C_ALT = 32'h3;
  localparam logic [31:0] C_SLOW = 32'h10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [CNT_W-1:0]  bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [CNT_W-1:0]  bus_rdata;
  logic              bus_rvalid;
  logic              irq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [31:0] cyc = '0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  evt_timebase #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOW_DIV(SLOW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (sb.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL unexpected read data got %h expected none", bus_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        nchk++;
        if (bus_rdata !== it.exp) begin
          nfail++;
          $display("FAIL %s got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    it.exp = (a == A_TIME) ? cyc : e;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    nchk++;
    if (irq_o !== e) begin
      nfail++;
      $display("FAIL %s irq_o got %b expected %b", tag, irq_o, e);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired got hang expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_irq(1'b0, "R1 reset irq");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_DIV,  32'h0, "R1 div");
    rd(A_CNT,  32'h0, "R1 count");
    rd(A_MST,  32'h0, "R1 mstat");

    // R10 timebase
    rd(A_TIME, 32'h0, "R10 time a");
    rd(A_TIME, 32'h0, "R10 time b");

    // R11 readback
    wr(A_DIV, 32'd10);
    rd(A_DIV, 32'd10, "R11 div readback");
    wr(A_MASK, 32'h1);
    rd(A_MASK, 32'h1, "R11 mask readback");
    wr(A_CTRL, C_SLOW | C_HOLD);
    rd(A_CTRL, C_SLOW, "R11 ctrl readback");

    // R3 load then hold
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_HOLD);
    rd(A_CNT, 32'd10, "R3 loaded count");

    // R4 full-rate expiry timing
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    repeat (10) @(negedge clk);
    chk_irq(1'b0, "R4 before expiry");
    @(negedge clk);
    chk_irq(1'b1, "R4 at expiry+1");
    rd(A_MST, 32'h1, "R7 mstat set");

    // R6 sticky zero
    rd(A_CNT, 32'h0, "R6 count zero");
    repeat (5) @(negedge clk);
    rd(A_CNT, 32'h0, "R6 count still zero");

    // R8 acknowledge
    wr(A_ACK, 32'h1);
    @(negedge clk);
    chk_irq(1'b0, "R8 irq cleared");
    rd(A_MST, 32'h0, "R8 mstat cleared");

    // R9 ack with bit0 clear, minimum divisor
    wr(A_DIV, 32'd2);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    repeat (4) @(negedge clk);
    chk_irq(1'b1, "R12 min divisor expiry");
    wr(A_ACK, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R9 ack bit0=0 ignored");
    rd(A_MST, 32'h1, "R9 mstat kept");
    wr(A_ACK, 32'h1);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R8 clear again");

    // R8 expiry and ack on the same edge
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    wr(A_ACK, 32'h1);
    rd(A_MST, 32'h1, "R8 set wins");
    wr(A_ACK, 32'h1);

    // R7 masked expiry
    wr(A_MASK, 32'h0);
    wr(A_DIV, 32'd3);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    repeat (8) @(negedge clk);
    chk_irq(1'b0, "R7 masked no irq");
    rd(A_MST, 32'h0, "R7 masked status");
    wr(A_MASK, 32'h1);
    rd(A_MST, 32'h1, "R7 unmasked status");
    chk_irq(1'b1, "R7 unmasked irq");
    wr(A_ACK, 32'h1);

    // R3 elapsed = divisor - count
    wr(A_DIV, 32'd100);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    repeat (5) @(negedge clk);
    wr(A_CTRL, C_HOLD);
    rd(A_CNT, 32'd93, "R3 after 7 steps");

    // R2 code 3 acts as hold
    wr(A_CTRL, C_RUN);
    wr(A_CTRL, C_ALT);
    rd(A_CNT, 32'd91, "R2 run two steps");
    repeat (5) @(negedge clk);
    rd(A_CNT, 32'd91, "R2 code3 frozen");

    // R5 slow rate
    wr(A_DIV, 32'd3);
    wr(A_CTRL, C_SLOW | C_LOAD);
    wr(A_CTRL, C_SLOW | C_RUN);
    repeat (3*SLOW) @(negedge clk);
    chk_irq(1'b0, "R5 slow not yet");
    @(negedge clk);
    chk_irq(1'b1, "R5 slow expiry");
    wr(A_ACK, 32'h1);

    // R12 maximum divisor
    wr(A_DIV, 32'hFFFF_FFFF);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_HOLD);
    rd(A_CNT, 32'hFFFF_FFFF, "R12 max loaded");
    wr(A_CTRL, C_RUN);
    wr(A_CTRL, C_HOLD);
    rd(A_CNT, 32'hFFFF_FFFD, "R12 max two steps");

    rd(A_TIME, 32'h0, "R10 time late");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL R11 missing read data got %0d pending expected 0", sb.size());
    end
    finish_up();
  end
endmodule